// File: doc/BRIEF.md
# Cascadable Four-Bit Datapath Slice

This block is one four-bit cut of a processor datapath. It holds a sixteen-entry register file of four-bit words with two read ports and an arithmetic/logic unit that offers eight functions. Any number of copies can be placed side by side to form a datapath of any multiple of four bits. All copies receive the same addresses and function code. Each copy gets its own nibble of the external data word. The carry output of each slice feeds the carry input of the next more significant slice, with no register between them.

In each cycle the slice reads two registers, A and B, in parallel. The first operand is either register A or the external data nibble. The second operand is always register B. The ALU result, the carry, a per-slice zero flag and the result's top bit as sign are all combinational outputs. When the write enable is high, the result is written back into register B on the rising clock edge. Program counter, sequencing and memory sit outside the slice.

Top module: `nibble_slice`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero. A write requested in a reset cycle is not performed.
- R2: Function code 0 (add) gives {carry_out, result} = P + Q + carry_in. P is the first operand and Q is register B.
- R3: When src_ext is 1, P is ext_din. When src_ext is 0, P is the register addressed by addr_a.
- R4: Function code 1 (reverse subtract) gives {carry_out, result} = Q + ~P + carry_in. With carry_in = 1 this is Q − P, and carry_out = 1 means no borrow.
- R5: Function code 2 (forward subtract) gives {carry_out, result} = P + ~Q + carry_in. With carry_in = 1 this is P − Q.
- R6: Function codes 3 to 7 are logic functions: 3 gives P|Q, 4 gives P&Q, 5 gives ~P&Q, 6 gives P^Q and 7 gives ~(P^Q). For all of these, carry_out is 0.
- R7: When wr_en is 1 at a rising edge, the result is written into the register at addr_b, and only into that register.
- R8: When wr_en is 0 at a rising edge, no register changes.
- R9: zero is 1 exactly when result is 0000. sign equals result bit 3.
- R10: carry_out follows carry_in with no clock in between. Four chained slices therefore perform correct 16-bit add and subtract. The AND of their zero flags is the word zero flag, and the top slice's sign is the word sign.
- R11: Both read ports may address the same register in one cycle. Each port then returns that register's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_a | input | 4 | Read address of register A |
| addr_b | input | 4 | Read address of register B and write-back address |
| ext_din | input | 4 | External data nibble |
| src_ext | input | 1 | 1 selects ext_din as first operand, 0 selects register A |
| func | input | 3 | ALU function code |
| wr_en | input | 1 | Write result into register B at the clock edge |
| carry_in | input | 1 | Carry from the next less significant slice |
| result | output | 4 | ALU result nibble |
| carry_out | output | 1 | Carry to the next more significant slice |
| zero | output | 1 | Result nibble is zero |
| sign | output | 1 | Most significant bit of the result |

## Verification
The bound checker runs on every cycle. It checks that a write lands in register B and is visible on the B read port one cycle later, and that B holds its value when no write is enabled. It also checks the reset clear, the add result against the selected operands, and the forced-zero carry of the logic functions. Only the bench scenarios can show behaviour across several slices. These include a carry rippling through all four nibbles, borrow behaviour of both subtract directions at word level, the word zero and sign flags, and the fact that a write leaves register A and every other register untouched.

// File: rtl/slice_pkg.sv
package slice_pkg;

    // Width of one slice and depth of its register file
    parameter int SLICE_W  = 4;
    parameter int RF_DEPTH = 16;
    parameter int FN_W     = 3;

    // ALU function codes; the numbering is visible at the ports
    typedef enum logic [FN_W-1:0] {
        FN_ADD    = 3'd0,
        FN_SUBR   = 3'd1,
        FN_SUBS   = 3'd2,
        FN_OR     = 3'd3,
        FN_AND    = 3'd4,
        FN_ANDNOT = 3'd5,
        FN_XOR    = 3'd6,
        FN_XNOR   = 3'd7
    } slice_fn_e;

    // The two ALU operands of the slice
    typedef struct packed {
        logic [SLICE_W-1:0] p;   // first operand: register A or external data
        logic [SLICE_W-1:0] q;   // second operand: register B
    } operand_t;

    // ALU output bundle
    typedef struct packed {
        logic [SLICE_W-1:0] y;
        logic               cout;
    } alu_out_t;

    // Functions that use the adder
    function automatic logic fn_is_arith(slice_fn_e fn);
        return (fn == FN_ADD) || (fn == FN_SUBR) || (fn == FN_SUBS);
    endfunction

    // Which operand the adder inverts for a function
    function automatic logic fn_inv_p(slice_fn_e fn);
        return fn == FN_SUBR;
    endfunction

    function automatic logic fn_inv_q(slice_fn_e fn);
        return fn == FN_SUBS;
    endfunction

endpackage

// File: rtl/slice_regfile.sv
module slice_regfile
    import slice_pkg::*;
#(
    parameter int W     = SLICE_W,
    parameter int DEPTH = RF_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] cells [DEPTH];

    // One storage word per entry, each with its own decoded write strobe
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [W-1:0] cell_q;
        logic         hit;

        assign hit = we && (waddr == AW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (hit) begin
                cell_q <= wdata;
            end
        end

        assign cells[i] = cell_q;
    end

    // Two independent asynchronous read ports
    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/slice_opsel.sv
module slice_opsel
    import slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         src_ext,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] ext_din,
    input  logic [W-1:0] reg_b,
    output operand_t     ops
);

    always_comb begin
        ops   = '0;
        ops.p = src_ext ? ext_din : reg_a;
        ops.q = reg_b;
    end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  slice_fn_e fn,
    input  operand_t  ops,
    input  logic      cin,
    output alu_out_t  out
);

    logic [W-1:0] add_p;
    logic [W-1:0] add_q;
    logic [W:0]   sum;
    logic [W-1:0] logic_y;

    // Shared adder: subtraction inverts one operand and relies on carry-in
    always_comb begin
        add_p = fn_inv_p(fn) ? ~ops.p : ops.p;
        add_q = fn_inv_q(fn) ? ~ops.q : ops.q;
        sum   = {1'b0, add_p} + {1'b0, add_q} + {{W{1'b0}}, cin};
    end

    // Bitwise functions
    always_comb begin
        unique case (fn)
            FN_OR:     logic_y = ops.p | ops.q;
            FN_AND:    logic_y = ops.p & ops.q;
            FN_ANDNOT: logic_y = ~ops.p & ops.q;
            FN_XOR:    logic_y = ops.p ^ ops.q;
            FN_XNOR:   logic_y = ~(ops.p ^ ops.q);
            default:   logic_y = '0;
        endcase
    end

    always_comb begin
        out = '0;
        if (fn_is_arith(fn)) begin
            out.y    = sum[W-1:0];
            out.cout = sum[W];
        end else begin
            out.y    = logic_y;
            out.cout = 1'b0;
        end
    end

endmodule

// File: rtl/slice_flags.sv
module slice_flags
    import slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] y,
    output logic         zero,
    output logic         sign
);

    assign zero = ~|y;
    assign sign = y[W-1];

endmodule

// File: rtl/nibble_slice.sv
module nibble_slice
    import slice_pkg::*;
#(
    parameter int W     = SLICE_W,
    parameter int DEPTH = RF_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic [W-1:0]  ext_din,
    input  logic          src_ext,
    input  logic [2:0]    func,
    input  logic          wr_en,
    input  logic          carry_in,
    output logic [W-1:0]  result,
    output logic          carry_out,
    output logic          zero,
    output logic          sign
);

    logic [W-1:0] rd_a;
    logic [W-1:0] rd_b;
    operand_t     ops;
    alu_out_t     alu_o;
    slice_fn_e    fn;

    assign fn = slice_fn_e'(func);

    slice_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (addr_b),
        .wdata   (alu_o.y),
        .raddr_a (addr_a),
        .raddr_b (addr_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    slice_opsel #(.W(W)) u_sel (
        .src_ext (src_ext),
        .reg_a   (rd_a),
        .ext_din (ext_din),
        .reg_b   (rd_b),
        .ops     (ops)
    );

    slice_alu #(.W(W)) u_alu (
        .fn  (fn),
        .ops (ops),
        .cin (carry_in),
        .out (alu_o)
    );

    slice_flags #(.W(W)) u_flg (
        .y    (alu_o.y),
        .zero (zero),
        .sign (sign)
    );

    assign result    = alu_o.y;
    assign carry_out = alu_o.cout;

endmodule

// File: rtl/slice_checker.sv
module slice_checker #(
    parameter int W  = 4,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr_b,
    input logic [W-1:0]  ext_din,
    input logic          src_ext,
    input logic [2:0]    func,
    input logic          wr_en,
    input logic          carry_in,
    input logic [W-1:0]  result,
    input logic          carry_out,
    input logic [W-1:0]  rdata_a,
    input logic [W-1:0]  rdata_b
);

    logic [W-1:0] first_op;
    assign first_op = src_ext ? ext_din : rdata_a;

    // R1: the cycle after a reset both read ports see cleared registers
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (rdata_a == '0 && rdata_b == '0));

    // R2 and R3: add result matches the selected operands
    assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (func == 3'd0) |->
            ({carry_out, result} == ({1'b0, first_op} + {1'b0, rdata_b} + {{W{1'b0}}, carry_in})));

    // R6: logic functions never produce a carry
    assert_logic_nocarry_R6: assert property (@(posedge clk) disable iff (rst)
        (func >= 3'd3) |-> (carry_out == 1'b0));

    // R7: a written result shows up on the B port next cycle
    assert_writeback_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en ##1 (addr_b == $past(addr_b))) |-> (rdata_b == $past(result)));

    // R8: without a write the B register holds its value
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en ##1 (addr_b == $past(addr_b))) |-> (rdata_b == $past(rdata_b)));

endmodule

bind nibble_slice slice_checker #(.W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_b    (addr_b),
    .ext_din   (ext_din),
    .src_ext   (src_ext),
    .func      (func),
    .wr_en     (wr_en),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .rdata_a   (rd_a),
    .rdata_b   (rd_b)
);

// File: tb/tb_nibble_slice.sv
`timescale 1ns/1ps
module tb_nibble_slice;

    localparam int NS = 4;   // slices in the word
    localparam int WW = 16;  // word width

    logic clk = 1'b0;
    logic rst;
    logic [3:0]    addr_a, addr_b;
    logic [WW-1:0] din_w;
    logic          src_ext, wr_en, cin_w;
    logic [2:0]    func;

    logic [3:0] res_s [NS];
    logic       cy    [NS+1];
    logic       zf    [NS];
    logic       sg    [NS];

    always #4 clk = ~clk;   // 125 MHz

    assign cy[0] = cin_w;

    for (genvar i = 0; i < NS; i++) begin : g_sl
        nibble_slice dut (
            .clk       (clk),
            .rst       (rst),
            .addr_a    (addr_a),
            .addr_b    (addr_b),
            .ext_din   (din_w[4*i +: 4]),
            .src_ext   (src_ext),
            .func      (func),
            .wr_en     (wr_en),
            .carry_in  (cy[i]),
            .result    (res_s[i]),
            .carry_out (cy[i+1]),
            .zero      (zf[i]),
            .sign      (sg[i])
        );
    end

    logic [WW-1:0] res_w;
    logic          zero_w;
    assign res_w  = {res_s[3], res_s[2], res_s[1], res_s[0]};
    assign zero_w = zf[0] & zf[1] & zf[2] & zf[3];

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [WW-1:0] mdl [16];

    // Word-level reference model of the requirements
    task automatic run_op(input string req, input logic [2:0] fn, input int a, input int b,
                          input logic se, input logic [WW-1:0] din, input logic ci,
                          input logic we);
        logic [WW-1:0] p, q, ey;
        logic [WW:0]   s;
        logic          ec;
        p = se ? din : mdl[a];
        q = mdl[b];
        s = '0;
        case (fn)
            3'd0: s = {1'b0, p} + {1'b0, q} + {{WW{1'b0}}, ci};
            3'd1: s = {1'b0, q} + {1'b0, ~p} + {{WW{1'b0}}, ci};
            3'd2: s = {1'b0, p} + {1'b0, ~q} + {{WW{1'b0}}, ci};
            3'd3: s = {1'b0, p | q};
            3'd4: s = {1'b0, p & q};
            3'd5: s = {1'b0, ~p & q};
            3'd6: s = {1'b0, p ^ q};
            default: s = {1'b0, ~(p ^ q)};
        endcase
        ey = s[WW-1:0];
        ec = s[WW];
        @(negedge clk);
        func = fn; addr_a = 4'(a); addr_b = 4'(b); src_ext = se;
        din_w = din; cin_w = ci; wr_en = we;
        #1;
        checks++;
        if (res_w !== ey || cy[NS] !== ec || zero_w !== (ey == '0) || sg[NS-1] !== ey[WW-1]) begin
            errors++;
            $display("FAIL %s fn=%0d: got y=%h c=%b z=%b s=%b, expected y=%h c=%b z=%b s=%b",
                     req, fn, res_w, cy[NS], zero_w, sg[NS-1], ey, ec, (ey == '0), ey[WW-1]);
        end
        if (we) mdl[b] = ey;
    endtask

    task automatic load_reg(input int k, input logic [WW-1:0] v);
        run_op("R11", 3'd6, k, k, 1'b0, '0, 1'b0, 1'b1);  // clear via self-XOR
        run_op("R7",  3'd3, 0, k, 1'b1, v,  1'b0, 1'b1);  // OR in the value
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 16; k++)
            run_op("R1", 3'd3, k, k, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_add();
        load_reg(1, 16'h1234);
        load_reg(2, 16'h0FFF);
        run_op("R2",  3'd0, 1, 2, 1'b0, '0, 1'b0, 1'b0);
        run_op("R10", 3'd0, 1, 2, 1'b0, '0, 1'b1, 1'b0);
        load_reg(3, 16'hFFFF);
        run_op("R10", 3'd0, 0, 3, 1'b1, 16'h0001, 1'b0, 1'b0);  // full ripple to zero
        run_op("R9",  3'd0, 0, 2, 1'b1, 16'h7001, 1'b0, 1'b0);  // sign set
    endtask

    task automatic t_srcsel();
        run_op("R3", 3'd0, 1, 2, 1'b1, 16'h0100, 1'b0, 1'b0);
        run_op("R3", 3'd0, 1, 2, 1'b0, 16'h0100, 1'b0, 1'b0);
    endtask

    task automatic t_sub();
        run_op("R4", 3'd1, 2, 1, 1'b0, '0, 1'b1, 1'b0);  // no borrow
        run_op("R4", 3'd1, 1, 2, 1'b0, '0, 1'b1, 1'b0);  // borrow
        run_op("R5", 3'd2, 1, 2, 1'b0, '0, 1'b1, 1'b0);
        run_op("R5", 3'd2, 1, 1, 1'b0, '0, 1'b1, 1'b0);  // equal gives zero
        run_op("R5", 3'd2, 0, 3, 1'b1, 16'h8000, 1'b0, 1'b0);
    endtask

    task automatic t_logic();
        load_reg(4, 16'hA5C3);
        for (int f = 3; f < 8; f++) begin
            run_op("R6", 3'(f), 0, 4, 1'b1, 16'h3C5A, 1'b1, 1'b0);
        end
    endtask

    task automatic t_write();
        run_op("R7", 3'd0, 1, 2, 1'b0, '0, 1'b0, 1'b1);  // r2 <= r1 + r2
        run_op("R7", 3'd3, 0, 2, 1'b1, '0, 1'b0, 1'b0);  // read r2
        run_op("R7", 3'd3, 0, 1, 1'b1, '0, 1'b0, 1'b0);  // r1 (port A) untouched
        run_op("R7", 3'd3, 0, 3, 1'b1, '0, 1'b0, 1'b0);  // neighbour untouched
    endtask

    task automatic t_nowrite();
        run_op("R8", 3'd6, 4, 4, 1'b0, '0, 1'b0, 1'b0);  // would clear r4 if written
        run_op("R8", 3'd3, 0, 4, 1'b1, '0, 1'b0, 1'b0);  // r4 still holds
    endtask

    task automatic t_reset_write();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; func = 3'd3; src_ext = 1'b1;
        din_w = 16'hBEEF; addr_b = 4'd5;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        for (int k = 0; k < 16; k++) mdl[k] = '0;
        run_op("R1", 3'd3, 0, 5, 1'b1, '0, 1'b0, 1'b0);
        run_op("R1", 3'd3, 0, 4, 1'b1, '0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 16; k++) mdl[k] = '0;
        rst = 1'b1; addr_a = '0; addr_b = '0; din_w = '0;
        src_ext = 1'b0; wr_en = 1'b0; cin_w = 1'b0; func = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_srcsel();
        t_sub();
        t_logic();
        t_write();
        t_nowrite();
        t_reset_write();
        idle();
        finish_run();
    end

endmodule